// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block holds a configuration image in a byte-wide array and sends it out one bit at a time on a single data line. The bit pointer steps on each rising edge of an externally supplied data clock. An enable input gates both the data line and the stepping. Depending on a stored polarity choice, the same input also clears the pointer when held at its other level. An active-low select input puts the block into standby when it is high.

Several instances can be chained to carry an image longer than one array holds. Each instance's cascade output drives the select input of the next one. When an instance has sent its last bit, it lowers its cascade output and lets go of the shared data line, so the next instance takes over on the following clock edges. The level of the select input while the pointer is being cleared decides the role: the first device in the chain or a follower.

A power-on interval after system reset keeps the block quiet and holds a ready flag low. A serial-enable input, when low, parks the block in an idle state with its output floating. The data clock is brought into the system clock domain through a two-stage synchronizer with rising-edge detection. The array is loaded through a plain byte write port.

Top module: `cfg_stream_reader`

## Requirements
- R1: While the enable input is at its clearing level and serial enable is high, the bit pointer returns to bit 0 and the data line floats (data_oe_o low), whatever the select level.
- R2: With select high, the data line floats whatever the enable input, and data-clock edges do not move the bit pointer.
- R3: With enable active, select low, serial enable high and ready high, the data line is driven. Each synchronized data-clock rising edge advances the pointer by one bit. Bit address b reads byte b/8 at bit position 7-(b mod 8), so bytes go out most significant bit first, starting at byte 0.
- R4: A rising edge while the last bit is shown makes cascade_n_o go low, and it stays low through further data-clock edges.
- R5: Once cascade_n_o is low, data_oe_o is low.
- R6: master_o follows the inverse of the select input during clearing: select low gives master_o = 1, select high gives master_o = 0.
- R7: With enable_pol_i = 1 the enable input is active high and clears when low. With enable_pol_i = 0 these levels swap.
- R8: For POR_CYCLES clocks after system reset is released, ready_o is low, the pointer sits at bit 0 and the data line floats. After that, ready_o is high.
- R9: With serial enable low, the data line floats and data-clock edges do not move the pointer.
- R10: Clearing the pointer also returns cascade_n_o high.
- R11: In a chain where cascade_n_o of one instance drives the select of the next, the second instance outputs its own bit 0 as soon as the first has finished, and then streams its image on the following edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset, starts the power-on interval |
| serial_en_i | input | 1 | High for streaming, low for idle (programming) |
| enable_pol_i | input | 1 | Stored polarity bit: 1 means the enable input is active high |
| enable_i | input | 1 | Output enable; its inactive level clears the pointer |
| sel_n_i | input | 1 | Active-low select |
| dclk_i | input | 1 | Data clock, asynchronous to clk |
| wr_en_i | input | 1 | Array byte write strobe |
| wr_addr_i | input | BYTE_AW | Array byte address |
| wr_data_i | input | 8 | Array byte value |
| data_o | output | 1 | Serial data, 0 when not driven |
| data_oe_o | output | 1 | High when data_o should drive the shared line |
| cascade_n_o | output | 1 | Low once the last bit has been sent |
| master_o | output | 1 | Role captured during clearing (1 means first in chain) |
| ready_o | output | 1 | Low during the power-on interval |

## Verification
The assertions assume that enable, select and serial-enable change only on system clock edges. They also assume that every data-clock level lasts at least three system clocks, so that each data-clock rise yields exactly one single-cycle edge pulse. The stimulus holds every data-clock level for six clocks and drives control inputs only on falling clock edges. It samples outputs only after those six clocks, once the synchronizer and the pointer register have settled.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    typedef enum logic {
        ROLE_FOLLOWER = 1'b0,
        ROLE_FIRST    = 1'b1
    } role_e;

    // bit position inside a byte for a serial bit address, MSB first
    function automatic logic [2:0] msb_first_pos(input logic [2:0] low);
        return 3'd7 - low;
    endfunction

endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [2:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[1] & ~sh_q[2];

    // a detected edge lasts exactly one cycle (R3)
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/cfg_bit_store.sv
module cfg_bit_store
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH_BYTES = 256,
    localparam int BYTE_AW = $clog2(DEPTH_BYTES),
    localparam int BIT_AW  = BYTE_AW + 3
) (
    input  logic               clk,
    input  logic               wr_en_i,
    input  logic [BYTE_AW-1:0] wr_addr_i,
    input  logic [7:0]         wr_data_i,
    input  logic [BIT_AW-1:0]  rd_addr_i,
    output logic               rd_bit_o
);
    logic [7:0] mem_q [DEPTH_BYTES];
    logic [7:0] rd_byte;

    always_ff @(posedge clk) begin
        if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
    end

    assign rd_byte  = mem_q[rd_addr_i[BIT_AW-1:3]];
    assign rd_bit_o = rd_byte[msb_first_pos(rd_addr_i[2:0])];

endmodule

// File: rtl/cfg_stream_reader.sv
module cfg_stream_reader
    import cfg_stream_pkg::*;
#(
    parameter int DEPTH_BYTES = 256,
    parameter int POR_CYCLES  = 8,
    localparam int BYTE_AW = $clog2(DEPTH_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               serial_en_i,
    input  logic               enable_pol_i,
    input  logic               enable_i,
    input  logic               sel_n_i,
    input  logic               dclk_i,
    input  logic               wr_en_i,
    input  logic [BYTE_AW-1:0] wr_addr_i,
    input  logic [7:0]         wr_data_i,
    output logic               data_o,
    output logic               data_oe_o,
    output logic               cascade_n_o,
    output logic               master_o,
    output logic               ready_o
);
    localparam int BIT_AW = BYTE_AW + 3;
    localparam int PW     = $clog2(POR_CYCLES + 1);
    localparam logic [BIT_AW-1:0] LAST_BIT = BIT_AW'(DEPTH_BYTES * 8 - 1);
    localparam logic [PW-1:0]     POR_LAST = PW'(POR_CYCLES - 1);

    typedef struct packed {
        logic [BIT_AW-1:0] addr;
        logic              done;
        role_e             role;
        logic [PW-1:0]     por_cnt;
        logic              ready;
    } state_t;

    state_t st_d, st_q;
    logic   dclk_rise;
    logic   cur_bit;
    logic   enable_lvl;
    logic   clear_lvl;
    logic   active;

    cfg_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dclk_i),
        .rise_o  (dclk_rise)
    );

    cfg_bit_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (st_q.addr),
        .rd_bit_o  (cur_bit)
    );

    assign enable_lvl = enable_pol_i ? enable_i : ~enable_i;
    assign clear_lvl  = ~enable_lvl;
    assign active     = st_q.ready & serial_en_i & enable_lvl & ~sel_n_i;

    always_comb begin
        st_d = st_q;
        if (!st_q.ready) begin
            st_d.addr    = '0;
            st_d.done    = 1'b0;
            st_d.por_cnt = st_q.por_cnt + 1'b1;
            st_d.role    = sel_n_i ? ROLE_FOLLOWER : ROLE_FIRST;
            if (st_q.por_cnt == POR_LAST) st_d.ready = 1'b1;
        end else if (serial_en_i && clear_lvl) begin
            st_d.addr = '0;
            st_d.done = 1'b0;
            st_d.role = sel_n_i ? ROLE_FOLLOWER : ROLE_FIRST;
        end else if (active && dclk_rise && !st_q.done) begin
            if (st_q.addr == LAST_BIT) st_d.done = 1'b1;
            else                       st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, done: 1'b0, role: ROLE_FOLLOWER,
                      por_cnt: '0, ready: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign data_oe_o   = active & ~st_q.done;
    assign data_o      = data_oe_o & cur_bit;
    assign cascade_n_o = ~st_q.done;
    assign master_o    = (st_q.role == ROLE_FIRST);
    assign ready_o     = st_q.ready;

    // clearing returns pointer to bit 0 and raises cascade (R1, R10)
    p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && serial_en_i && clear_lvl) |=> (st_q.addr == '0 && cascade_n_o));

    // standby keeps the pointer still (R2)
    p_standby_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && sel_n_i && enable_lvl) |=> $stable(st_q.addr));

    // one edge moves the pointer one bit (R3)
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && dclk_rise && !st_q.done && st_q.addr != LAST_BIT)
        |=> st_q.addr == BIT_AW'($past(st_q.addr) + 1'b1));

    // cascade falls only from the last bit (R4)
    p_casc_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cascade_n_o) |-> ($past(st_q.addr) == LAST_BIT && $past(dclk_rise)));

    // finished device never drives the line (R5)
    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cascade_n_o |-> !data_oe_o);

    // quiet during power-on interval (R8)
    p_por_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (!data_oe_o && cascade_n_o && st_q.addr == '0));

    // idle mode holds the pointer (R9)
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ready && !serial_en_i) |=> $stable(st_q.addr));

endmodule

// File: tb/cfg_stream_reader_tb.sv
module cfg_stream_reader_tb;
    localparam int DEPTH = 2;
    localparam int NBITS = DEPTH * 8;
    localparam int HOLD  = 6;

    typedef struct packed {
        logic en;
        logic sel_n;
        logic pulse;
        logic e_oe;
        logic e_dat;
        logic e_casc;
    } vec_t;

    // image 0 = A5 3C, bits of A5 MSB first: 1 0 1 0 0 1 0 1
    localparam vec_t TBL [10] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 clearing
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 bit0
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 bit1
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},  // R3 bit2
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 standby, edge ignored
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},  // R2 still bit2
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R3 bit3
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R1 clear with select high
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 edge during clear
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}   // R1 back at bit0
    };

    localparam logic [7:0] IMG0 [DEPTH] = '{8'hA5, 8'h3C};
    localparam logic [7:0] IMG1 [DEPTH] = '{8'hF0, 8'h96};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serial_en = 1'b1;
    logic pol = 1'b1;
    logic en = 1'b0;
    logic sel_n = 1'b0;
    logic dclk = 1'b0;
    logic wr0 = 1'b0, wr1 = 1'b0;
    logic [0:0] wa = '0;
    logic [7:0] wd = '0;
    logic d0, oe0, c0, m0, r0;
    logic d1, oe1, c1, m1, r1;
    logic bus;
    int vec_cnt = 0;
    int err_cnt = 0;

    always #2 clk = ~clk;

    assign bus = oe0 ? d0 : (oe1 ? d1 : 1'b0);

    cfg_stream_reader #(.DEPTH_BYTES(DEPTH), .POR_CYCLES(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .serial_en_i(serial_en), .enable_pol_i(pol),
        .enable_i(en), .sel_n_i(sel_n), .dclk_i(dclk),
        .wr_en_i(wr0), .wr_addr_i(wa), .wr_data_i(wd),
        .data_o(d0), .data_oe_o(oe0), .cascade_n_o(c0), .master_o(m0), .ready_o(r0)
    );

    cfg_stream_reader #(.DEPTH_BYTES(DEPTH), .POR_CYCLES(8)) u_nxt (
        .clk(clk), .rst_n(rst_n), .serial_en_i(serial_en), .enable_pol_i(pol),
        .enable_i(en), .sel_n_i(c0), .dclk_i(dclk),
        .wr_en_i(wr1), .wr_addr_i(wa), .wr_data_i(wd),
        .data_o(d1), .data_oe_o(oe1), .cascade_n_o(c1), .master_o(m1), .ready_o(r1)
    );

    function automatic logic img_bit(input logic [7:0] b0, input logic [7:0] b1, input int b);
        logic [7:0] by;
        by = (b / 8 == 0) ? b0 : b1;
        return by[7 - (b % 8)];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        vec_cnt++;
        if (act !== exp) begin
            err_cnt++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        dclk = 1'b1;
        wait_n(HOLD);
        dclk = 1'b0;
        wait_n(HOLD);
    endtask

    task automatic apply(input logic e, input logic s, input logic p);
        en = e;
        sel_n = s;
        wait_n(HOLD);
        if (p) pulse();
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
        $finish;
    endtask

    initial begin
        wait_n(150000);
        err_cnt++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // load images while in system reset
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wa = 1'(i); wd = IMG0[i]; wr0 = 1'b1; wr1 = 1'b0;
            @(negedge clk);
            wd = IMG1[i]; wr0 = 1'b0; wr1 = 1'b1;
        end
        @(negedge clk);
        wr1 = 1'b0;
        en = 1'b1;
        sel_n = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R8 power-on interval
        chk("R8 ready low after reset", r0, 1'b0);
        chk("R8 line floats in power-on", oe0, 1'b0);
        wait_n(12);
        chk("R8 ready high after interval", r0, 1'b1);

        // vector table walk
        for (int v = 0; v < 10; v++) begin
            apply(TBL[v].en, TBL[v].sel_n, TBL[v].pulse);
            chk("R1/R2/R3 table oe", oe0, TBL[v].e_oe);
            if (TBL[v].e_oe) chk("R3 table data", d0, TBL[v].e_dat);
            chk("R4 table cascade", c0, TBL[v].e_casc);
        end

        // full stream across the chain
        apply(1'b0, 1'b0, 1'b0);
        chk("R6 first device role", m0, 1'b1);
        chk("R6 follower role", m1, 1'b0);
        apply(1'b1, 1'b0, 1'b0);
        chk("R11 follower floats while first streams", oe1, 1'b0);
        for (int b = 0; b < NBITS; b++) begin
            chk("R3 first device drives", oe0, 1'b1);
            chk("R3 first device bit", bus, img_bit(IMG0[0], IMG0[1], b));
            pulse();
        end
        chk("R4 cascade low at end", c0, 1'b0);
        chk("R5 first device released", oe0, 1'b0);
        chk("R11 follower takes over", oe1, 1'b1);
        for (int b = 0; b < NBITS; b++) begin
            chk("R11 follower bit", bus, img_bit(IMG1[0], IMG1[1], b));
            pulse();
            chk("R4 cascade stays low", c0, 1'b0);
        end
        chk("R4 follower cascade low", c1, 1'b0);
        chk("R5 follower released", oe1, 1'b0);

        // R10 clearing raises cascades again
        apply(1'b0, 1'b0, 1'b0);
        chk("R10 first cascade high", c0, 1'b1);
        chk("R10 follower cascade high", c1, 1'b1);
        chk("R6 follower role after clear", m1, 1'b0);

        // R6 role with select high at clear
        apply(1'b0, 1'b1, 1'b0);
        chk("R6 select high gives follower", m0, 1'b0);
        apply(1'b0, 1'b0, 1'b0);
        chk("R6 select low gives first", m0, 1'b1);

        // R7 inverted polarity
        pol = 1'b0;
        apply(1'b1, 1'b0, 1'b0);
        chk("R7 high level clears when inverted", oe0, 1'b0);
        apply(1'b0, 1'b0, 1'b0);
        chk("R7 low level enables when inverted", oe0, 1'b1);
        chk("R7 bit0 when inverted", d0, 1'b1);
        pulse();
        chk("R7 bit1 when inverted", d0, 1'b0);
        pol = 1'b1;
        apply(1'b0, 1'b0, 1'b0);

        // R9 idle mode
        apply(1'b1, 1'b0, 1'b1);
        chk("R9 at bit1 before idle", d0, 1'b0);
        serial_en = 1'b0;
        wait_n(HOLD);
        chk("R9 idle floats", oe0, 1'b0);
        pulse();
        serial_en = 1'b1;
        wait_n(HOLD);
        chk("R9 pointer unchanged by idle edge", d0, 1'b0);
        chk("R9 driven again", oe0, 1'b1);
        pulse();
        chk("R9 advances after idle", d0, 1'b1);

        finish_run();
    end
endmodule